// File: doc/BRIEF.md
# Byte-Command Counter-Mode Register Front End

This block turns a stream of command bytes into accesses to a small register set that drives an external 128-bit block cipher in counter mode. One input byte names a register and an operation. A write command takes the next input byte as its payload. A read command puts one byte on the output stream. The key, nonce, data-in and data-out registers are wider than a byte, so software reaches them by repeating single-byte commands at the same address. An internal byte index walks through the register.

The block holds a 32-bit counter. The counter block sent to the cipher is the nonce followed by that counter. A control write either reloads the counter or lets it run on from its last value, and it starts an operation through a level request. When the cipher answers with a done pulse, the block stores data-in XOR keystream in data-out, advances the counter and reports completion in the control register.

Top module: `ctr_byte_front`

## Requirements
- R1: A command byte carries the register address in bits 6:4 and the opcode in bits 3:0; bit 7 is ignored. Opcode 0x0 reads and 0x1 writes. Any other opcode is consumed as a single byte with no effect, and it does not move any byte index.
- R2: A write command consumes exactly one following payload byte. A read command produces one output byte. That byte is held stable with valid high until it is taken, and no input byte is accepted while it is pending.
- R3: Address 1 is a 128-bit key, address 2 a 96-bit nonce, address 3 a 128-bit data-in and address 4 a 128-bit data-out. Byte index 0 is the most significant byte. Each access to the same address as the previous access advances the index by one, and the index wraps after the last byte (index 15, or 11 for the nonce).
- R4: An access to a mapped address that differs from the previous accessed address starts at byte index 0. An access to address 0 also counts as a change of address.
- R5: A control write (address 0) with bits 2 and 1 set loads the counter with 1 and raises the cipher request. With bit 2 set and bit 1 clear, the request rises and the counter keeps its value. The counter block is {nonce, counter}, with the counter big-endian in the low 32 bits. While running, control reads back the written value with only bits 2:1 kept.
- R6: On the done pulse, data-out becomes data-in XOR the cipher output, control reads exactly 0x08, the request drops and the counter increases by one.
- R7: A control write with bit 0 set clears control, key, nonce and data-in to zero and cancels a running request. Data-out and the counter are kept.
- R8: Reads of addresses 5 to 7 return 0x00. Writes to addresses 4 to 7 consume their payload and change no register and no byte index.
- R9: The cipher request stays high until done. Control writes without bit 0 that arrive while the request is high are ignored.
- R10: The cipher key output always equals the key register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Block can take an input byte |
| m_tdata | output | 8 | Read response byte |
| m_tvalid | output | 1 | Read response valid |
| m_tready | input | 1 | Consumer takes the response |
| cipher_req | output | 1 | Cipher operation request, held until done |
| cipher_key | output | 128 | Key to the cipher |
| cipher_block | output | 128 | Counter block to the cipher |
| cipher_done | input | 1 | One-cycle completion pulse |
| cipher_out | input | 128 | Keystream block, valid with done |

## Verification
The assertions assume that the cipher pulses done only while a request is high and that the keystream is valid in that same cycle. The bench stub follows this. It responds only to a raised request, after a random delay of 0 to 3 cycles, and it can be frozen to keep the request open. The assertions also assume that the consumer of the output stream is the only thing that withdraws a response. The bench raises m_tready only after it has checked the byte, and it holds m_tready low for several cycles in a backpressure case. Input bytes are driven between clock edges with a fixed-seed random mix of keys, nonces, data, restart choices and command bit 7, next to directed index, reserved-opcode and reset cases.

// File: rtl/ctr_byte_front.sv
module ctr_byte_front #(
  parameter int NONCE_BYTES = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   s_tdata,
  input  logic         s_tvalid,
  output logic         s_tready,
  output logic [7:0]   m_tdata,
  output logic         m_tvalid,
  input  logic         m_tready,
  output logic         cipher_req,
  output logic [127:0] cipher_key,
  output logic [127:0] cipher_block,
  input  logic         cipher_done,
  input  logic [127:0] cipher_out
);
  localparam int NW    = 8 * NONCE_BYTES;
  localparam int CTR_W = 128 - NW;
  localparam logic [6:0] NTOP = 7'(NW - 8);

  logic [127:0]     key_q, din_q, dout_q;
  logic [NW-1:0]    nonce_q;
  logic [CTR_W-1:0] ctr_q;
  logic [7:0]       ctrl_q, rd_byte, m_data_q;
  logic             busy_q, pend_q, m_valid_q;
  logic [2:0]       wr_addr_q, last_q;
  logic [3:0]       idx_q;

  function automatic logic [3:0] last_idx(input logic [2:0] a);
    case (a)
      3'd1, 3'd3, 3'd4: last_idx = 4'd15;
      3'd2:             last_idx = 4'(NONCE_BYTES - 1);
      default:          last_idx = 4'd0;
    endcase
  endfunction

  wire       acc    = s_tvalid && s_tready;
  wire [2:0] c_addr = s_tdata[6:4];
  wire       is_rd  = acc && !pend_q && s_tdata[3:0] == 4'h0;
  wire       is_wrc = acc && !pend_q && s_tdata[3:0] == 4'h1;
  wire       is_pay = acc && pend_q;
  wire [2:0] a_sel  = pend_q ? wr_addr_q : c_addr;
  wire       touch  = (is_rd && c_addr <= 3'd4) || (is_pay && wr_addr_q <= 3'd3);
  wire [3:0] cur    = (a_sel == last_q) ? idx_q : 4'd0;
  wire [3:0] nxt    = (cur == last_idx(a_sel)) ? 4'd0 : cur + 4'd1;
  wire [6:0] sh     = {cur, 3'b000};
  wire       ctl_wr = is_pay && wr_addr_q == 3'd0;
  wire       rst_wr = ctl_wr && s_tdata[0];
  wire       finish = busy_q && cipher_done && !rst_wr;

  assign s_tready     = !m_valid_q;
  assign m_tvalid     = m_valid_q;
  assign m_tdata      = m_data_q;
  assign cipher_req   = busy_q;
  assign cipher_key   = key_q;
  assign cipher_block = {nonce_q, ctr_q};

  always_comb begin
    case (c_addr)
      3'd0:    rd_byte = ctrl_q;
      3'd1:    rd_byte = key_q[7'd120 - sh +: 8];
      3'd2:    rd_byte = nonce_q[NTOP - sh +: 8];
      3'd3:    rd_byte = din_q[7'd120 - sh +: 8];
      3'd4:    rd_byte = dout_q[7'd120 - sh +: 8];
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      wr_addr_q <= '0;
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
      last_q    <= '0;
      idx_q     <= '0;
    end else begin
      if (is_wrc) begin
        pend_q    <= 1'b1;
        wr_addr_q <= c_addr;
      end else if (is_pay) begin
        pend_q <= 1'b0;
      end
      if (m_valid_q && m_tready) m_valid_q <= 1'b0;
      if (is_rd) begin
        m_valid_q <= 1'b1;
        m_data_q  <= rd_byte;
      end
      if (touch) begin
        last_q <= a_sel;
        idx_q  <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      nonce_q <= '0;
      din_q   <= '0;
      dout_q  <= '0;
      ctr_q   <= '0;
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (is_pay) begin
        case (wr_addr_q)
          3'd1: key_q[7'd120 - sh +: 8]  <= s_tdata;
          3'd2: nonce_q[NTOP - sh +: 8]  <= s_tdata;
          3'd3: din_q[7'd120 - sh +: 8]  <= s_tdata;
          default: ;
        endcase
      end
      if (rst_wr) begin
        ctrl_q  <= '0;
        key_q   <= '0;
        nonce_q <= '0;
        din_q   <= '0;
        busy_q  <= 1'b0;
      end else if (ctl_wr && !busy_q) begin
        ctrl_q <= {5'b0, s_tdata[2:1], 1'b0};
        if (s_tdata[2]) begin
          busy_q <= 1'b1;
          if (s_tdata[1]) ctr_q <= CTR_W'(1);
        end
      end
      if (finish) begin
        dout_q <= din_q ^ cipher_out;
        ctrl_q <= 8'h08;
        busy_q <= 1'b0;
        ctr_q  <= ctr_q + CTR_W'(1);
      end
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !cipher_done && !rst_wr |=> cipher_req);

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ctrl_q == 8'h08 && !cipher_req);

  p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> cipher_block[CTR_W-1:0] == $past(cipher_block[CTR_W-1:0]) + CTR_W'(1));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !busy_q && s_tdata[2:0] == 3'b110 |=> cipher_req && cipher_block[CTR_W-1:0] == CTR_W'(1));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> !cipher_req && ctrl_q == 8'h00 && cipher_key == 128'h0);

  always_ff @(posedge clk) begin
    if (rst_n) p_idx_range_r3: assert (idx_q <= last_idx(last_q));
  end
endmodule

// File: tb/sim_ctr_byte_front.sv
module sim_ctr_byte_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] s_tdata = 0;
  logic s_tvalid = 0, m_tready = 0;
  logic s_tready, m_tvalid, cipher_req;
  logic [7:0] m_tdata;
  logic [127:0] cipher_key, cipher_block, cipher_out = 0;
  logic cipher_done = 0;

  ctr_byte_front u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [7:0] km [16], nm [12], dm [16], om [16];
  logic [7:0] ctrl_m = 0;
  logic [31:0] ctr_m = 0;
  int idx_m = 0, last_m = 0;
  bit busy_m = 0, freeze = 0;
  int stub_cnt = 0;

  function automatic logic [127:0] ks(input logic [127:0] k, input logic [127:0] b);
    return k ^ {b[70:0], b[127:71]} ^ 128'h5a3c_96e1_0f0f_1234_c3a5_7e81_dead_beef;
  endfunction

  always @(negedge clk) begin
    if (cipher_req && !cipher_done && !freeze) begin
      if (stub_cnt == 0) begin
        cipher_done <= 1;
        cipher_out  <= ks(cipher_key, cipher_block);
        stub_cnt    <= int'($urandom % 4);
      end else stub_cnt <= stub_cnt - 1;
    end else cipher_done <= 0;
  end

  function automatic int lastidx(input int a);
    return (a == 2) ? 11 : (a >= 1 && a <= 4) ? 15 : 0;
  endfunction

  function automatic int mtouch(input int a);
    int c;
    c = (a == last_m) ? idx_m : 0;
    idx_m = (c == lastidx(a)) ? 0 : c + 1;
    last_m = a;
    return c;
  endfunction

  function automatic logic [127:0] pack16(input int which);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = (which == 1) ? km[i] : (which == 3) ? dm[i] : om[i];
    return r;
  endfunction

  function automatic logic [127:0] mblock();
    logic [127:0] r;
    for (int i = 0; i < 12; i++) r[127-8*i -: 8] = nm[i];
    r[31:0] = ctr_m;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!s_tready) @(negedge clk);
    s_tvalid = 1; s_tdata = b;
    @(negedge clk);
    s_tvalid = 0;
  endtask

  function automatic logic [7:0] b7();
    return ($urandom % 2) ? 8'h80 : 8'h00;
  endfunction

  task automatic wr(input int a, input logic [7:0] v);
    int c;
    send(b7() | 8'(a << 4) | 8'h01);
    send(v);
    if (a <= 3) begin
      c = mtouch(a);
      case (a)
        1: km[c] = v;
        2: nm[c] = v;
        3: dm[c] = v;
        default: begin
          if (v[0]) begin
            ctrl_m = 0; busy_m = 0;
            for (int i = 0; i < 16; i++) begin km[i] = 0; dm[i] = 0; end
            for (int i = 0; i < 12; i++) nm[i] = 0;
          end else if (!busy_m) begin
            ctrl_m = v & 8'h06;
            if (v[2]) begin busy_m = 1; if (v[1]) ctr_m = 1; end
          end
        end
      endcase
    end
  endtask

  task automatic rd(input int a, input string tag);
    logic [7:0] e;
    int c;
    e = 0;
    if (a <= 4) begin
      c = mtouch(a);
      case (a)
        0: e = ctrl_m;
        1: e = km[c];
        2: e = nm[c];
        3: e = dm[c];
        default: e = om[c];
      endcase
    end
    send(b7() | 8'(a << 4));
    chk({tag, " valid"}, m_tvalid, 1);
    chk(tag, m_tdata, e);
    m_tready = 1;
    @(negedge clk);
    m_tready = 0;
  endtask

  task automatic wait_finish(input string tag);
    int n;
    n = 0;
    while (cipher_req && n < 50) begin @(negedge clk); n++; end
    chk({tag, " req drop"}, cipher_req, 0);
    for (int i = 0; i < 16; i++) om[i] = dm[i];
    begin
      logic [127:0] o;
      o = pack16(3) ^ ks(pack16(1), mblock());
      for (int i = 0; i < 16; i++) om[i] = o[127-8*i -: 8];
    end
    ctrl_m = 8'h08; busy_m = 0; ctr_m++;
  endtask

  task automatic run_op(input logic [7:0] cv, input string tag);
    wr(0, cv);
    chk({tag, " R5 req"}, cipher_req, 1);
    chk({tag, " R5 block"}, cipher_block, mblock());
    chk({tag, " R10 key"}, cipher_key, pack16(1));
    wait_finish(tag);
    for (int i = 0; i < 16; i++) rd(4, {tag, " R6 dout"});
    rd(0, {tag, " R6 ctrl"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired got 1 exp 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 16; i++) begin km[i] = 0; dm[i] = 0; om[i] = 0; end
    for (int i = 0; i < 12; i++) nm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset m_tvalid", m_tvalid, 0);
    chk("reset req", cipher_req, 0);
    chk("reset s_tready", s_tready, 1);
    rd(0, "reset R7 ctrl");
    rd(1, "reset key");

    for (int i = 0; i < 3; i++) wr(1, 8'(8'h10 + i));
    rd(0, "R4 ctrl between");
    for (int i = 0; i < 16; i++) wr(1, 8'(8'h20 + 7 * i));
    send(8'h15);
    for (int i = 0; i < 17; i++) rd(1, "R3 R1 key walk");
    for (int i = 0; i < 14; i++) wr(2, 8'(8'hA0 + i));
    for (int i = 0; i < 12; i++) rd(2, "R3 nonce wrap");
    for (int i = 0; i < 16; i++) wr(3, 8'(8'h31 * i));
    rd(5, "R8 addr5"); rd(6, "R8 addr6"); rd(7, "R8 addr7");
    send(8'h41); send(8'hFF);
    send(8'h61); send(8'h01);
    rd(0, "R8 ctrl after ignored writes");
    for (int i = 0; i < 2; i++) rd(3, "R8 din index kept");
    for (int i = 0; i < 14; i++) rd(3, "R3 din rest");

    run_op(8'h06, "op1");
    run_op(8'h04, "op2 continue");

    send(8'h00);
    repeat (3) begin
      @(negedge clk);
      chk("R2 hold valid", m_tvalid, 1);
      chk("R2 hold data", m_tdata, ctrl_m);
      chk("R2 no accept", s_tready, 0);
    end
    void'(mtouch(0));
    m_tready = 1; @(negedge clk); m_tready = 0;
    chk("R2 released", m_tvalid, 0);

    freeze = 1;
    wr(0, 8'h04);
    wr(0, 8'h02);
    rd(0, "R9 ctrl while busy");
    chk("R9 req held", cipher_req, 1);
    freeze = 0;
    wait_finish("R9 op");
    for (int i = 0; i < 16; i++) rd(4, "R9 dout");

    freeze = 1;
    wr(0, 8'h04);
    wr(0, 8'h01);
    chk("R7 req cancel", cipher_req, 0);
    freeze = 0;
    rd(0, "R7 ctrl"); rd(1, "R7 key"); rd(2, "R7 nonce"); rd(3, "R7 din");
    for (int i = 0; i < 16; i++) rd(4, "R7 dout kept");

    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 16; i++) wr(1, 8'($urandom));
      if (n == 0 || ($urandom % 2)) for (int i = 0; i < 12; i++) wr(2, 8'($urandom));
      for (int i = 0; i < 16; i++) wr(3, 8'($urandom));
      run_op((n == 0 || ($urandom % 2)) ? 8'h06 : 8'h04, "rand R5 R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule